// File: doc/BRIEF.md
# Multi-channel edge-programmable PWM generator

This block drives six pulse-width-modulated outputs from one shared up-counter and seven match values. Match value 0 sets the period: the counter advances on each prescaled count tick and returns to zero on the tick where it equals match value 0. Every output can run in one of two modes. In single-edge mode the output rises at the start of each period and falls at its own match value. In double-edge mode it rises at the previous match value and falls at its own, so the pulse can be placed anywhere in the period. Double-edge mode makes phase-shifted, non-overlapping outputs possible. Each match value also raises a one-cycle interrupt pulse when it hits.

Software writes match values into shadow registers through a plain write port. A latch command arms a transfer, and the shadow values move into the active set only at the next period wrap. A half-written set of edges therefore never reaches the outputs. Mode and enable bits take effect at once. The write port has no back-pressure: a write with `cfg_we` high is taken on the same rising edge, every cycle. The count tick and all outputs are plain level signals with no handshake.

Top module: `pwm_edge_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pwm_o` and `match_irq_o` are all zero. All match values, mode bits and enable bits reset to 0, so the period is one tick.
- R2: The counter changes only on a clock edge with `cnt_tick` high. On such an edge it returns to 0 if it equals active match 0, and otherwise increments by one. The period is therefore active match 0 plus one ticks.
- R3: When mode bit k is 0 (single-edge), `pwm_o[k]` is set on the tick where the counter wraps and cleared on the tick where the counter equals active match k+1. Each change is visible one clock after that edge, so the output is high while the counter runs from 0 through match k+1.
- R4: When mode bit k is 1 (double-edge), `pwm_o[k]` is set on the tick where the counter equals active match k and cleared on the tick where it equals active match k+1. For k = 0 the set point is the wrap itself.
- R5: If the set event and the clear event of an output fall on the same tick, the output goes low. If the clear match value is larger than match 0, the output is never cleared and stays high once set.
- R6: A write to addresses 0 to 6 stores `cfg_wdata` in shadow match register 0 to 6 and changes no output. Any write to address 9 arms a transfer. At the next wrap, all seven shadow values become active and the arming clears. Matches on that wrap edge still use the old values.
- R7: A write to address 8 loads the enable bits from `cfg_wdata[5:0]`, bit k for `pwm_o[k]`. An output whose enable bit is 0 is low from the next clock onward. Once re-enabled, it stays low until its next set event.
- R8: `match_irq_o[i]` is high for exactly one clock, one clock after an edge with `cnt_tick` high on which the counter equals active match i. It is never high otherwise.
- R9: A write to address 7 loads the mode bits from `cfg_wdata[5:0]` (1 selects double-edge for `pwm_o[k]`). Mode and enable writes act on the tick evaluations of the clock edge after the write edge, without waiting for a wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Prescaled count enable; the counter moves on edges where it is high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Write address: 0-6 shadow matches, 7 mode, 8 enable, 9 latch arm |
| cfg_wdata | input | 16 | Write data |
| pwm_o | output | 6 | PWM outputs |
| match_irq_o | output | 7 | One-cycle pulse per match register hit |

## Verification
Every output is registered once after the tick edge that causes it. Outputs and interrupt pulses therefore change exactly one clock after the rising edge on which `cnt_tick` and the counter value produce the event. A register write affects the evaluation of the following edge, and a latched shadow set affects the evaluation after the next wrap edge. The bench drives inputs on the falling edge and advances its own model by one step per rising edge. It then compares both output vectors on the next falling edge, so each expected value is due exactly one clock after the stimulus that produces it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DOUBLE = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int CW     = 16,
  parameter int NOUT   = 6,
  parameter int NMATCH = NOUT + 1,
  parameter int AW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wdata,
  input  logic            wrap,
  output logic [CW-1:0]   act_o [NMATCH],
  output logic [NOUT-1:0] mode_o,
  output logic [NOUT-1:0] en_o
);
  localparam logic [AW-1:0] ADDR_MODE  = AW'(NMATCH);
  localparam logic [AW-1:0] ADDR_EN    = AW'(NMATCH + 1);
  localparam logic [AW-1:0] ADDR_LATCH = AW'(NMATCH + 2);

  logic [CW-1:0] shadow [NMATCH];
  logic          armed;
  logic          commit;

  assign commit = wrap && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        armed <= 1'b0;
    else if (we && addr == ADDR_LATCH) armed <= 1'b1;
    else if (wrap)                     armed <= 1'b0;
  end

  for (genvar i = 0; i < NMATCH; i++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[i] <= '0;
        act_o[i]  <= '0;
      end else begin
        if (we && addr == AW'(i)) shadow[i] <= wdata;
        if (commit)               act_o[i]  <= shadow[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0;
      en_o   <= '0;
    end else if (we) begin
      if (addr == ADDR_MODE) mode_o <= wdata[NOUT-1:0];
      if (addr == ADDR_EN)   en_o   <= wdata[NOUT-1:0];
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW     = 16,
  parameter int NMATCH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CW-1:0]     act [NMATCH],
  output logic [CW-1:0]     cnt_o,
  output logic [NMATCH-1:0] ev_o
);
  for (genvar i = 0; i < NMATCH; i++) begin : g_cmp
    assign ev_o[i] = tick && (cnt_o == act[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (tick)  cnt_o <= ev_o[0] ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  edge_mode_e mode,
  input  logic       ev_start,
  input  logic       ev_lead,
  input  logic       ev_trail,
  output logic       out
);
  logic set_ev;

  assign set_ev = (mode == EDGE_DOUBLE) ? ev_lead : ev_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out <= 1'b0;
    else if (!en)      out <= 1'b0;
    else if (ev_trail) out <= 1'b0;
    else if (set_ev)   out <= 1'b1;
  end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_pkg::*;
#(
  parameter int CW     = 16,
  parameter int NOUT   = 6,
  localparam int NMATCH = NOUT + 1,
  localparam int AW     = $clog2(NMATCH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic [NOUT-1:0]   pwm_o,
  output logic [NMATCH-1:0] match_irq_o
);
  logic [CW-1:0]        act [NMATCH];
  logic [NMATCH*CW-1:0] act_flat;
  logic [NOUT-1:0]      mode_q;
  logic [NOUT-1:0]      en_q;
  logic [CW-1:0]        cnt;
  logic [NMATCH-1:0]    ev;

  pwm_regs #(.CW(CW), .NOUT(NOUT), .NMATCH(NMATCH), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .wrap   (ev[0]),
    .act_o  (act),
    .mode_o (mode_q),
    .en_o   (en_q)
  );

  pwm_timebase #(.CW(CW), .NMATCH(NMATCH)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (cnt_tick),
    .act   (act),
    .cnt_o (cnt),
    .ev_o  (ev)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_ch
    pwm_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q[k]),
      .mode     (edge_mode_e'(mode_q[k])),
      .ev_start (ev[0]),
      .ev_lead  (ev[k]),
      .ev_trail (ev[k+1]),
      .out      (pwm_o[k])
    );
  end

  for (genvar i = 0; i < NMATCH; i++) begin : g_flat
    assign act_flat[i*CW +: CW] = act[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_irq_o <= '0;
    else        match_irq_o <= ev;
  end
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int CW     = 16,
  parameter int NOUT   = 6,
  parameter int NMATCH = NOUT + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_tick,
  input logic [CW-1:0]     cnt,
  input logic [NMATCH*CW-1:0] act_flat,
  input logic [NOUT-1:0]   en_q,
  input logic [NOUT-1:0]   pwm_o,
  input logic [NMATCH-1:0] match_irq_o
);
  logic [CW-1:0] act0;
  assign act0 = act_flat[CW-1:0];

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act0); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && cnt == act0) |=> (cnt == '0)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(cnt)); // R2

  AST_ACTIVE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_tick && cnt == act0) |=> $stable(act_flat)); // R6

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pwm_o & ~$past(en_q)) == '0)); // R7

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_irq_o) |-> $past(cnt_tick)); // R8

  AST_IRQ0_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq_o[0] |-> (cnt == '0)); // R8
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.CW(CW), .NOUT(NOUT), .NMATCH(NMATCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_tick    (cnt_tick),
  .cnt         (cnt),
  .act_flat    (act_flat),
  .en_q        (en_q),
  .pwm_o       (pwm_o),
  .match_irq_o (match_irq_o)
);

// File: tb/pwm_edge_gen_tb.sv
module pwm_edge_gen_tb;
  localparam int CW = 16;
  localparam int NOUT = 6;
  localparam int NM = NOUT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [NOUT-1:0] pwm_o;
  logic [NM-1:0] match_irq_o;

  always #4 clk = ~clk;

  pwm_edge_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pwm_o(pwm_o),
    .match_irq_o(match_irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  logic [CW-1:0] m_cnt;
  logic [CW-1:0] m_act [NM];
  logic [CW-1:0] m_sh [NM];
  logic [NOUT-1:0] m_mode, m_en, m_out;
  logic [NM-1:0] m_irq;
  logic m_arm;

  function automatic logic [NOUT-1:0] next_out(logic [NM-1:0] ev,
      logic [NOUT-1:0] mode, logic [NOUT-1:0] en, logic [NOUT-1:0] cur);
    logic [NOUT-1:0] r;
    for (int k = 0; k < NOUT; k++) begin
      logic s;
      s = mode[k] ? ev[k] : ev[0];
      if (!en[k])       r[k] = 1'b0;
      else if (ev[k+1]) r[k] = 1'b0;
      else if (s)       r[k] = 1'b1;
      else              r[k] = cur[k];
    end
    return r;
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_mode = '0; m_en = '0; m_out = '0; m_irq = '0; m_arm = 1'b0;
    for (int i = 0; i < NM; i++) begin m_act[i] = '0; m_sh[i] = '0; end
  endtask

  task automatic model_step(logic tk, logic we, logic [3:0] a, logic [CW-1:0] d);
    logic [NM-1:0] ev;
    logic wrap;
    for (int i = 0; i < NM; i++) ev[i] = tk && (m_cnt == m_act[i]);
    wrap = ev[0];
    m_out = next_out(ev, m_mode, m_en, m_out);
    m_irq = ev;
    if (tk) m_cnt = wrap ? '0 : m_cnt + 1'b1;
    if (wrap && m_arm)
      for (int i = 0; i < NM; i++) m_act[i] = m_sh[i];
    if (we && a == 4'd9) m_arm = 1'b1;
    else if (wrap)       m_arm = 1'b0;
    if (we && a < 4'd7) m_sh[a] = d;
    if (we && a == 4'd7) m_mode = d[NOUT-1:0];
    if (we && a == 4'd8) m_en = d[NOUT-1:0];
  endtask

  task automatic check();
    n_chk++;
    if (pwm_o !== m_out || match_irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s: pwm=%b irq=%b expected pwm=%b irq=%b", tag,
               pwm_o, match_irq_o, m_out, m_irq);
    end
  endtask

  task automatic cyc(logic tk, logic we, logic [3:0] a, logic [CW-1:0] d);
    cnt_tick = tk; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    model_step(tk, we, a, d);
    @(negedge clk);
    check();
  endtask

  task automatic wr(logic [3:0] a, logic [CW-1:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic run(int n, int tick_pct);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < tick_pct, 1'b0, 4'd0, '0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; check();
    rst_n = 1'b1;
    @(negedge clk);
    check();
    tag = "R1"; run(4, 100);

    tag = "R6";
    wr(4'd0, 16'd9); wr(4'd1, 16'd1); wr(4'd2, 16'd3); wr(4'd3, 16'd4);
    wr(4'd4, 16'd6); wr(4'd5, 16'd7); wr(4'd6, 16'd8);
    wr(4'd8, 16'h3F);
    run(20, 100);

    tag = "R3";
    wr(4'd9, 16'd0);
    run(40, 100);

    tag = "R4";
    wr(4'd7, 16'h3F);
    run(30, 100);

    tag = "R5";
    wr(4'd2, 16'd1); wr(4'd4, 16'd15); wr(4'd7, 16'h00); wr(4'd9, 16'd0);
    run(40, 100);
    wr(4'd7, 16'h3F);
    run(30, 100);

    tag = "R7";
    wr(4'd8, 16'h15);
    run(25, 100);
    wr(4'd8, 16'h3F);
    run(25, 100);

    tag = "R8";
    run(60, 40);

    tag = "R2";
    wr(4'd0, 16'd4); wr(4'd9, 16'd0);
    run(60, 60);

    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 8)
        cyc(($urandom % 2) == 1, 1'b1, 4'($urandom % 7), CW'($urandom % 16));
      else if (r < 11)
        cyc(($urandom % 2) == 1, 1'b1, 4'd7, CW'($urandom));
      else if (r < 14)
        cyc(($urandom % 2) == 1, 1'b1, 4'd8, CW'($urandom));
      else if (r < 17)
        cyc(($urandom % 2) == 1, 1'b1, 4'd9, '0);
      else
        cyc(($urandom % 100) < 70, 1'b0, 4'd0, '0);
    end
    if (seed == 0) tag = "R9";

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule